// File: doc/BRIEF.md
# Patch Burst-Load Command Controller

This block handles a host command that opens a patch burst load. The host presents a parallel command word, a one-cycle start strobe and a flag that says whether the device is running its application. The block decodes the bundle length, the secondary bus target address and the burst timeout from the word. It checks these fields and answers with an 8-bit status code one cycle after the strobe.

When the fields are accepted, the block stores the target address and enters a load phase. During that phase each incoming patch byte is written to patch RAM at a running pointer, and a timeout counter is decremented on every external 100 ms tick. The load ends when the declared byte count has arrived, or ends with a timeout flag if the counter reaches zero first. A repeated start during the load keeps the original fields and restarts the load from the beginning. A start in application mode is refused and changes nothing.

Top module: `patch_burst_ctrl`

## Requirements
- R1: After reset, status_valid, cmd_reject, burst_active, burst_done, burst_timeout and ram_we are 0, and tgt_addr is 0x00.
- R2: Byte n of the command sits at cmd_data[8n+7:8n]. The bundle length is {byte4, byte3, byte2, byte1} with byte4 most significant. The address is byte5[6:0] and the timeout is byte6[5:0]. Byte 0, byte5[7] and byte6[7:6] have no effect.
- R3: A bundle length of zero, or one above PATCH_BYTES, gives status 0x04.
- R4: An address in 0x00–0x07 or 0x78–0x7F, or an address equal to own_addr, gives status 0x05.
- R5: A timeout of zero gives status 0x06. The fields are checked in the order length, address, timeout, and only the first failure is reported.
- R6: The cycle after any cmd_start, status_valid is 1 for that command. Valid fields give status 0x00, load the address into tgt_addr and set burst_active.
- R7: A start with app_mode high gives status 0xFF together with cmd_reject. It changes no address, phase, pointer or timer.
- R8: While burst_active is high, a byte with pb_valid drives ram_we, ram_addr equal to the pointer and ram_wdata equal to pb_data, then advances the pointer. Bytes outside the load phase, or in a start cycle, are not written.
- R9: When the pointer reaches the bundle length, burst_done rises and burst_active falls.
- R10: Each tick_100ms during the load lowers the counter by one. If the counter reaches zero before the last byte, burst_active falls and burst_timeout rises.
- R11: A start without app_mode during the load returns 0x00. It ignores the new fields, reloads the counter with the first timeout and sets the pointer back to 0.
- R12: A rejected field check leaves tgt_addr and the phase outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_data | input | 56 | Command bytes 0..6 |
| app_mode | input | 1 | Device is in application mode |
| own_addr | input | 7 | Primary bus address of the device |
| tick_100ms | input | 1 | One-cycle pulse every 100 ms |
| pb_valid | input | 1 | Patch byte present |
| pb_data | input | 8 | Patch byte |
| ram_we | output | 1 | Patch RAM write enable |
| ram_addr | output | $clog2(PATCH_BYTES) | Patch RAM write address |
| ram_wdata | output | 8 | Patch RAM write data |
| status_valid | output | 1 | Status valid pulse |
| status | output | 8 | Command status code |
| cmd_reject | output | 1 | Command refused in application mode |
| tgt_addr | output | 7 | Secondary target address |
| burst_active | output | 1 | Load phase in progress |
| burst_done | output | 1 | All declared bytes received |
| burst_timeout | output | 1 | Load ended on timeout |

## Verification
If the pointer drifts, it shows on ram_addr at the very next accepted byte, and it shows again as burst_done arriving too early or too late. If the counter keeps a stale value after a restart, burst_timeout rises a tick too soon, or burst_active lasts too long, and this is seen within the number of ticks the timeout specifies. A wrong field decode or a wrong check order shows as a wrong status code one cycle after the strobe. The bench places fields at their limits and sets the reserved bits, so that each of these errors reaches a port quickly.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
    localparam int BYTE_W    = 8;
    localparam int CMD_BYTES = 7;
    localparam int CMD_W     = BYTE_W * CMD_BYTES;
    localparam int SIZE_W    = 32;
    localparam int SADDR_W   = 7;
    localparam int TMO_W     = 6;

    localparam logic [7:0] ST_OK       = 8'h00;
    localparam logic [7:0] ST_BAD_SIZE = 8'h04;
    localparam logic [7:0] ST_BAD_ADDR = 8'h05;
    localparam logic [7:0] ST_BAD_TMO  = 8'h06;
    localparam logic [7:0] ST_REFUSED  = 8'hFF;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOAD    = 2'd1,
        PH_DONE    = 2'd2,
        PH_EXPIRED = 2'd3
    } phase_e;
endpackage

// File: rtl/pbl_cmd_check.sv
module pbl_cmd_check
    import pbl_pkg::*;
#(
    parameter int CAPACITY = 4096,
    parameter int RSV_LO   = 8'h08,
    parameter int RSV_HI   = 8'h78
) (
    input  logic [CMD_W-1:0]   cmd_data,
    input  logic [SADDR_W-1:0] own_addr,
    output logic [SIZE_W-1:0]  f_size,
    output logic [SADDR_W-1:0] f_addr,
    output logic [TMO_W-1:0]   f_tmo,
    output logic [7:0]         code
);
    localparam int SIZE_BYTES = SIZE_W / BYTE_W;
    localparam int ADDR_BYTE  = SIZE_BYTES + 1;
    localparam int TMO_BYTE   = SIZE_BYTES + 2;

    // Length bytes 1..4, byte 4 most significant.
    for (genvar gi = 0; gi < SIZE_BYTES; gi++) begin : g_size
        assign f_size[gi*BYTE_W +: BYTE_W] = cmd_data[(gi+1)*BYTE_W +: BYTE_W];
    end

    assign f_addr = cmd_data[ADDR_BYTE*BYTE_W +: SADDR_W];
    assign f_tmo  = cmd_data[TMO_BYTE*BYTE_W +: TMO_W];

    // Reserved bits: collected so they are read but affect nothing.
    logic unused_rsvd;
    assign unused_rsvd = ^{cmd_data[BYTE_W-1:0],
                           cmd_data[ADDR_BYTE*BYTE_W+SADDR_W +: BYTE_W-SADDR_W],
                           cmd_data[TMO_BYTE*BYTE_W+TMO_W +: BYTE_W-TMO_W]};

    logic size_bad, addr_bad, tmo_bad;

    always_comb begin
        size_bad = (f_size == '0) || (f_size > SIZE_W'(CAPACITY));
        addr_bad = (f_addr < SADDR_W'(RSV_LO)) || (f_addr >= SADDR_W'(RSV_HI))
                   || (f_addr == own_addr);
        tmo_bad  = (f_tmo == '0);
        if (size_bad)      code = ST_BAD_SIZE;
        else if (addr_bad) code = ST_BAD_ADDR;
        else if (tmo_bad)  code = ST_BAD_TMO;
        else               code = ST_OK;
    end
endmodule

// File: rtl/pbl_burst_timer.sv
module pbl_burst_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && tick && cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && tick && (cnt_q == W'(1));

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))); // R10
    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/pbl_write_ptr.sv
module pbl_write_ptr #(
    parameter int CAPACITY = 4096,
    parameter int PW = $clog2(CAPACITY + 1),
    parameter int AW = $clog2(CAPACITY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          adv,
    input  logic [PW-1:0] size_lim,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clear)    ptr_d = '0;
        else if (adv) ptr_d = ptr_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign addr = ptr_q[AW-1:0];
    assign last = adv && !clear && ((ptr_q + PW'(1)) == size_lim);

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= size_lim); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clear) |=> (ptr_q == $past(ptr_q) + PW'(1))); // R8
    AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr_q == '0)); // R11
endmodule

// File: rtl/patch_burst_ctrl.sv
module patch_burst_ctrl
    import pbl_pkg::*;
#(
    parameter int PATCH_BYTES = 4096,
    parameter int AW = $clog2(PATCH_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [55:0]         cmd_data,
    input  logic                app_mode,
    input  logic [6:0]          own_addr,
    input  logic                tick_100ms,
    input  logic                pb_valid,
    input  logic [7:0]          pb_data,
    output logic                ram_we,
    output logic [AW-1:0]       ram_addr,
    output logic [7:0]          ram_wdata,
    output logic                status_valid,
    output logic [7:0]          status,
    output logic                cmd_reject,
    output logic [6:0]          tgt_addr,
    output logic                burst_active,
    output logic                burst_done,
    output logic                burst_timeout
);
    localparam int PW = $clog2(PATCH_BYTES + 1);

    typedef struct packed {
        phase_e              phase;
        logic [SADDR_W-1:0]  tgt;
        logic [PW-1:0]       size;
        logic [TMO_W-1:0]    tmo;
        logic                stat_v;
        logic [7:0]          stat;
        logic                rej;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SIZE_W-1:0]  chk_size;
    logic [SADDR_W-1:0] chk_addr;
    logic [TMO_W-1:0]   chk_tmo;
    logic [7:0]         chk_code;

    pbl_cmd_check #(.CAPACITY(PATCH_BYTES)) u_check (
        .cmd_data (cmd_data),
        .own_addr (own_addr),
        .f_size   (chk_size),
        .f_addr   (chk_addr),
        .f_tmo    (chk_tmo),
        .code     (chk_code)
    );

    logic loading, host_cmd, restart, launch, reload, evt_ok, adv;
    logic tmr_expire, ptr_last;
    logic [TMO_W-1:0] tmr_val;

    always_comb begin
        loading  = (ctl_q.phase == PH_LOAD);
        host_cmd = cmd_start && !app_mode;
        restart  = host_cmd && loading;
        launch   = host_cmd && !loading && (chk_code == ST_OK);
        reload   = restart || launch;
        tmr_val  = launch ? chk_tmo : ctl_q.tmo;
        evt_ok   = loading && !host_cmd;
        adv      = evt_ok && pb_valid;
    end

    pbl_burst_timer #(.W(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (tmr_val),
        .run      (evt_ok),
        .tick     (tick_100ms),
        .expire   (tmr_expire)
    );

    pbl_write_ptr #(.CAPACITY(PATCH_BYTES), .PW(PW), .AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (reload),
        .adv      (adv),
        .size_lim (ctl_q.size),
        .addr     (ram_addr),
        .last     (ptr_last)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.stat_v = 1'b0;
        ctl_d.rej    = 1'b0;
        if (cmd_start) begin
            ctl_d.stat_v = 1'b1;
            if (app_mode) begin
                ctl_d.stat = ST_REFUSED;
                ctl_d.rej  = 1'b1;
            end else if (loading) begin
                ctl_d.stat = ST_OK;
            end else if (chk_code != ST_OK) begin
                ctl_d.stat = chk_code;
            end else begin
                ctl_d.stat  = ST_OK;
                ctl_d.phase = PH_LOAD;
                ctl_d.tgt   = chk_addr;
                ctl_d.size  = PW'(chk_size);
                ctl_d.tmo   = chk_tmo;
            end
        end
        if (evt_ok) begin
            if (ptr_last)        ctl_d.phase = PH_DONE;
            else if (tmr_expire) ctl_d.phase = PH_EXPIRED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ram_we        = adv;
    assign ram_wdata     = pb_data;
    assign status_valid  = ctl_q.stat_v;
    assign status        = ctl_q.stat;
    assign cmd_reject    = ctl_q.rej;
    assign tgt_addr      = ctl_q.tgt;
    assign burst_active  = (ctl_q.phase == PH_LOAD);
    assign burst_done    = (ctl_q.phase == PH_DONE);
    assign burst_timeout = (ctl_q.phase == PH_EXPIRED);

    AST_START_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> status_valid); // R6
    AST_REJECT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> (status_valid && status == ST_REFUSED)); // R7
    AST_REJECT_KEEPS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && app_mode) |=> $stable(tgt_addr)); // R7
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_done) |-> $past(ram_we)); // R9
    AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_timeout) |-> $past(tick_100ms)); // R10
    AST_RESTART_KEEPS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !app_mode && burst_active) |=> ($stable(tgt_addr) && burst_active)); // R11
endmodule

// File: tb/patch_burst_ctrl_bench.sv
module patch_burst_ctrl_bench;
    localparam int CAP = 4096;
    localparam int AW  = $clog2(CAP);

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cmd_start = 1'b0, app_mode = 1'b0, tick = 1'b0, pb_valid = 1'b0;
    logic [55:0]   cmd_data = '0;
    logic [6:0]    own_addr = 7'h2A;
    logic [7:0]    pb_data = '0;
    logic          ram_we, status_valid, cmd_reject, burst_active, burst_done, burst_timeout;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata, status;
    logic [6:0]    tgt_addr;

    int checks = 0;
    int errs   = 0;
    logic [6:0] tgt_exp = 7'h00;

    always #5ns clk = ~clk;

    patch_burst_ctrl #(.PATCH_BYTES(CAP)) u_patch_burst_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_data(cmd_data),
        .app_mode(app_mode), .own_addr(own_addr), .tick_100ms(tick),
        .pb_valid(pb_valid), .pb_data(pb_data), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .status_valid(status_valid), .status(status),
        .cmd_reject(cmd_reject), .tgt_addr(tgt_addr), .burst_active(burst_active),
        .burst_done(burst_done), .burst_timeout(burst_timeout)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [55:0] mk(logic [31:0] size, logic [7:0] ab, logic [7:0] tb, logic [7:0] b0);
        return {tb, ab, size, b0};
    endfunction

    function automatic logic [7:0] ref_status(logic [55:0] d, logic [6:0] own);
        logic [31:0] sz = d[39:8];
        logic [6:0]  a  = d[46:40];
        logic [5:0]  t  = d[53:48];
        if (sz == 0 || sz > CAP)                  return 8'h04;
        if (a < 7'h08 || a >= 7'h78 || a == own)  return 8'h05;
        if (t == 0)                               return 8'h06;
        return 8'h00;
    endfunction

    task automatic issue(logic [55:0] d, bit app, logic [7:0] exp_st, string req);
        @(negedge clk);
        cmd_data = d; app_mode = app; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; app_mode = 1'b0;
        chk(status_valid == 1'b1, req, "status_valid", status_valid, 1);
        chk(status == exp_st, req, "status", status, exp_st);
        chk(cmd_reject == (exp_st == 8'hFF), "R7", "cmd_reject", cmd_reject, exp_st == 8'hFF);
        chk(tgt_addr == tgt_exp, req, "tgt_addr", tgt_addr, tgt_exp);
    endtask

    task automatic feed(int n, int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pb_valid = 1'b1; pb_data = 8'($urandom);
            #1;
            chk(ram_we == 1'b1, "R8", "ram_we", ram_we, 1);
            chk(ram_addr == AW'(base + i), "R8", "ram_addr", ram_addr, base + i);
            chk(ram_wdata == pb_data, "R8", "ram_wdata", ram_wdata, pb_data);
        end
        @(negedge clk);
        pb_valid = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic phase_chk(bit a, bit d, bit t, string req);
        chk(burst_active == a, req, "burst_active", burst_active, a);
        chk(burst_done == d, req, "burst_done", burst_done, d);
        chk(burst_timeout == t, req, "burst_timeout", burst_timeout, t);
    endtask

    initial begin
        #3ms;
        errs++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status_valid == 0 && cmd_reject == 0 && ram_we == 0, "R1", "strobes", status_valid, 0);
        chk(tgt_addr == 7'h00, "R1", "tgt_addr", tgt_addr, 0);
        phase_chk(0, 0, 0, "R1");
        rst_n = 1'b1;
        // R8: byte while idle is not written
        @(negedge clk); pb_valid = 1'b1; #1;
        chk(ram_we == 1'b0, "R8", "idle ram_we", ram_we, 0);
        @(negedge clk); pb_valid = 1'b0;
        // R7: refused in application mode
        issue(mk(32'd4, 8'h55, 8'h03, 8'h00), 1'b1, 8'hFF, "R7");
        phase_chk(0, 0, 0, "R7");
        @(negedge clk);
        chk(status_valid == 1'b0, "R6", "status pulse end", status_valid, 0);
        // R3, R4, R5, R12 field checks and ordering
        issue(mk(32'd0, 8'h55, 8'h03, 8'h00), 1'b0, 8'h04, "R3");
        issue(mk(CAP + 1, 8'h00, 8'h00, 8'h00), 1'b0, 8'h04, "R3");
        issue(mk(CAP, 8'h78, 8'h00, 8'h00), 1'b0, 8'h05, "R5");
        issue(mk(CAP, {1'b0, own_addr}, 8'h01, 8'h00), 1'b0, 8'h05, "R4");
        issue(mk(32'd1, 8'h07, 8'h01, 8'h00), 1'b0, 8'h05, "R4");
        issue(mk(32'd1, 8'h7F, 8'h01, 8'h00), 1'b0, 8'h05, "R4");
        issue(mk(32'd1, 8'h08, 8'hC0, 8'h00), 1'b0, 8'h06, "R5");
        phase_chk(0, 0, 0, "R12");
        // R6, R2: success with reserved bits set
        tgt_exp = 7'h55;
        issue(mk(32'd4, 8'hD5, 8'hC3, 8'hA5), 1'b0, 8'h00, "R2");
        phase_chk(1, 0, 0, "R6");
        feed(2, 0);
        ticks(2);
        phase_chk(1, 0, 0, "R10");
        // R11: restart keeps fields, reloads timer, rewinds pointer
        issue(mk(32'd1, 8'h30, 8'h01, 8'h00), 1'b0, 8'h00, "R11");
        ticks(2);
        phase_chk(1, 0, 0, "R11");
        feed(3, 0);
        phase_chk(1, 0, 0, "R11");
        feed(1, 3);
        phase_chk(0, 1, 0, "R9");
        // R10: timeout path
        tgt_exp = 7'h40;
        issue(mk(32'd100, 8'h40, 8'h05, 8'h00), 1'b0, 8'h00, "R6");
        ticks(4);
        phase_chk(1, 0, 0, "R10");
        ticks(1);
        phase_chk(0, 0, 1, "R10");
        @(negedge clk); pb_valid = 1'b1; #1;
        chk(ram_we == 1'b0, "R8", "post-timeout ram_we", ram_we, 0);
        @(negedge clk); pb_valid = 1'b0;
        // Random commands against the reference
        for (int it = 0; it < 120; it++) begin
            logic [31:0] sz;
            logic [7:0]  ab, tb, es;
            logic [55:0] d;
            bit          app;
            case ($urandom_range(0, 5))
                0: sz = 0;
                2: sz = CAP;
                3: sz = CAP + 1;
                4: sz = $urandom;
                default: sz = $urandom_range(1, 12);
            endcase
            ab = 8'($urandom);
            if ($urandom_range(0, 9) < 3) ab[6:0] = own_addr;
            tb = {2'($urandom), 6'($urandom_range(0, 8))};
            d  = mk(sz, ab, tb, 8'($urandom));
            app = ($urandom_range(0, 9) == 0);
            es  = app ? 8'hFF : ref_status(d, own_addr);
            if (es == 8'h00) tgt_exp = ab[6:0];
            issue(d, app, es, es == 8'h00 ? "R6" : (app ? "R7" : "R12"));
            if (es == 8'h00) begin
                phase_chk(1, 0, 0, "R6");
                if (sz <= 12) begin
                    feed(int'(sz), 0);
                    phase_chk(0, 1, 0, "R9");
                end else begin
                    ticks(int'(tb[5:0]));
                    phase_chk(0, 0, 1, "R10");
                end
            end else begin
                chk(burst_active == 1'b0, "R12", "burst_active", burst_active, 0);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule